// File: doc/BRIEF.md
# Queue Status Interrupt Controller

This block raises interrupts for a queue manager that tracks 64 hardware queues. The queues form two groups of 32, a lower group and an upper group. Each group has its own enable register, its own sticky status register and its own interrupt line. For each lower queue, a 3-bit source code chooses one of four status flags and can complement it. Upper queues have no choice of source. They always signal when a queue leaves the nearly-empty state.

Software reaches the block through a plain 32-bit register port: a write strobe, a word address, write data and combinational read data. The per-queue flags arrive as parallel input vectors, one bit per queue. When a status bit is set and its enable bit is set, the group's interrupt line goes high. The line stays high until software clears the bit by writing 1 to it. The recommended order for turning a queue off is to clear its enable bit first and then clear its status bit. Every interface is a control or status pin, so there is no streaming handshake and no back-pressure.

Top module: `qstat_irq_top`

## Requirements
- R1: After reset, every register reads 0 and both interrupt lines are low. This holds while the upper nearly-empty inputs are all 1.
- R2: The source code of lower queue q sits in source register q/8 (word address q/8) at bits (q%8)*4+2 down to (q%8)*4. Bit 3 of each 4-bit field ignores writes and reads back 0.
- R3: Source code bits 1:0 select the flag: 0 empty, 1 nearly empty, 2 nearly full, 3 full. Bit 2 complements the selected flag, so code 7 means not full.
- R4: A lower status bit (address 6, bit q) is set one clock after the selected condition goes from 0 to 1 while the queue's enable bit (address 4, bit q) is 1.
- R5: No status bit is set while the queue's enable bit is 0. No status bit is set when the condition stays high without a new rising edge.
- R6: An upper status bit (address 7, bit q-32) is set one clock after the queue's nearly-empty input falls to 0 while its enable bit (address 5) is 1.
- R7: Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged. If a clear and a new rising edge arrive in the same cycle, the bit ends up set.
- R8: Each interrupt line is the OR over its group of status AND enable. Clearing an enable bit drops the line but keeps the status bit.
- R9: Address 8 reads the complement of the upper nearly-empty inputs (not nearly empty). Address 9 reads the upper full inputs. Writes to both addresses are ignored.
- R10: Addresses 10 to 15 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| lo_empty | input | 32 | Lower queues: empty flags |
| lo_near_empty | input | 32 | Lower queues: nearly-empty flags |
| lo_near_full | input | 32 | Lower queues: nearly-full flags |
| lo_full | input | 32 | Lower queues: full flags |
| hi_near_empty | input | 32 | Upper queues: nearly-empty flags |
| hi_full | input | 32 | Upper queues: full flags |
| irq_lo | output | 1 | Lower group interrupt |
| irq_hi | output | 1 | Upper group interrupt |

## Verification
For the lower source select, each vector sets up one flag state before arming the queue and then applies a second state. The expected status is the rising edge of the selected condition, with or without the complement. The vectors cover every code, a flag that stays high, and a rise on a flag the code does not select. Together they separate a wrong flag choice, a missing or misplaced inversion, and level detection used in place of edge detection. Further directed runs on queues in other source registers check the field packing. Directed tests on the upper group check the fixed falling-edge condition, a clear racing a new edge, masking by the enable bit, and the read-only mirrors.

// File: rtl/qstat_irq_pkg.sv
package qstat_irq_pkg;
  localparam int HALF_Q   = 32;
  localparam int REG_W    = 32;
  localparam int ADDR_W   = 4;
  localparam int FIELD_W  = 4;
  localparam int SEL_W    = 3;
  localparam int PER_REG  = REG_W / FIELD_W;
  localparam int SRC_REGS = HALF_Q / PER_REG;

  localparam logic [ADDR_W-1:0] A_EN_LO   = 4'd4;
  localparam logic [ADDR_W-1:0] A_EN_HI   = 4'd5;
  localparam logic [ADDR_W-1:0] A_ST_LO   = 4'd6;
  localparam logic [ADDR_W-1:0] A_ST_HI   = 4'd7;
  localparam logic [ADDR_W-1:0] A_HI_NNE  = 4'd8;
  localparam logic [ADDR_W-1:0] A_HI_FULL = 4'd9;

  typedef enum logic [1:0] {
    FLAG_EMPTY      = 2'd0,
    FLAG_NEAR_EMPTY = 2'd1,
    FLAG_NEAR_FULL  = 2'd2,
    FLAG_FULL       = 2'd3
  } flag_e;

  // bits that hold a source code; the top bit of each field stays zero
  function automatic logic [REG_W-1:0] field_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int f = 0; f < PER_REG; f++)
      m[f*FIELD_W +: SEL_W] = '1;
    return m;
  endfunction
endpackage

// File: rtl/qstat_cond_sel.sv
module qstat_cond_sel
  import qstat_irq_pkg::*;
#(
  parameter int N = HALF_Q
) (
  input  logic [N*FIELD_W-1:0] sel,
  input  logic [N-1:0]         f_empty,
  input  logic [N-1:0]         f_near_empty,
  input  logic [N-1:0]         f_near_full,
  input  logic [N-1:0]         f_full,
  output logic [N-1:0]         cond
);
  for (genvar q = 0; q < N; q++) begin : g_q
    logic raw;
    always_comb begin
      unique case (flag_e'(sel[q*FIELD_W +: 2]))
        FLAG_EMPTY:      raw = f_empty[q];
        FLAG_NEAR_EMPTY: raw = f_near_empty[q];
        FLAG_NEAR_FULL:  raw = f_near_full[q];
        default:         raw = f_full[q];
      endcase
    end
    assign cond[q] = raw ^ sel[q*FIELD_W + 2];
  end
endmodule

// File: rtl/qstat_half.sv
module qstat_half
  import qstat_irq_pkg::*;
#(
  parameter int N = HALF_Q
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cond,
  input  logic         en_we,
  input  logic         clr_we,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] en,
  output logic [N-1:0] st,
  output logic         irq
);
  logic [N-1:0] prev;
  logic [N-1:0] rise;
  logic [N-1:0] clr;

  assign rise = cond & ~prev;
  assign clr  = clr_we ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= '0;
      en   <= '0;
      st   <= '0;
    end else begin
      prev <= cond;
      if (en_we) en <= wdata;
      st <= (st & ~clr) | (rise & en);
    end
  end

  assign irq = |(st & en);
endmodule

// File: rtl/qstat_irq_top.sv
module qstat_irq_top
  import qstat_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [HALF_Q-1:0] lo_empty,
  input  logic [HALF_Q-1:0] lo_near_empty,
  input  logic [HALF_Q-1:0] lo_near_full,
  input  logic [HALF_Q-1:0] lo_full,
  input  logic [HALF_Q-1:0] hi_near_empty,
  input  logic [HALF_Q-1:0] hi_full,
  output logic              irq_lo,
  output logic              irq_hi
);
  localparam logic [REG_W-1:0] FMASK = field_mask();

  logic [SRC_REGS*REG_W-1:0] src_flat;
  logic [HALF_Q-1:0] cond_lo, cond_hi;
  logic [HALF_Q-1:0] en_lo, en_hi, st_lo, st_hi;

  for (genvar r = 0; r < SRC_REGS; r++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        src_flat[r*REG_W +: REG_W] <= '0;
      else if (reg_wr && reg_addr == ADDR_W'(r))
        src_flat[r*REG_W +: REG_W] <= reg_wdata & FMASK;
    end
  end

  qstat_cond_sel #(.N(HALF_Q)) u_sel (
    .sel(src_flat), .f_empty(lo_empty), .f_near_empty(lo_near_empty),
    .f_near_full(lo_near_full), .f_full(lo_full), .cond(cond_lo)
  );

  assign cond_hi = ~hi_near_empty;

  qstat_half #(.N(HALF_Q)) u_lo (
    .clk(clk), .rst_n(rst_n), .cond(cond_lo),
    .en_we(reg_wr && reg_addr == A_EN_LO),
    .clr_we(reg_wr && reg_addr == A_ST_LO),
    .wdata(reg_wdata), .en(en_lo), .st(st_lo), .irq(irq_lo)
  );

  qstat_half #(.N(HALF_Q)) u_hi (
    .clk(clk), .rst_n(rst_n), .cond(cond_hi),
    .en_we(reg_wr && reg_addr == A_EN_HI),
    .clr_we(reg_wr && reg_addr == A_ST_HI),
    .wdata(reg_wdata), .en(en_hi), .st(st_hi), .irq(irq_hi)
  );

  always_comb begin
    reg_rdata = '0;
    if (int'(reg_addr) < SRC_REGS)
      reg_rdata = src_flat[int'(reg_addr)*REG_W +: REG_W];
    else begin
      case (reg_addr)
        A_EN_LO:   reg_rdata = en_lo;
        A_EN_HI:   reg_rdata = en_hi;
        A_ST_LO:   reg_rdata = st_lo;
        A_ST_HI:   reg_rdata = st_hi;
        A_HI_NNE:  reg_rdata = ~hi_near_empty;
        A_HI_FULL: reg_rdata = hi_full;
        default:   reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/qstat_irq_chk.sv
module qstat_irq_chk
  import qstat_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [REG_W-1:0]  reg_rdata,
  input logic [HALF_Q-1:0] hi_near_empty,
  input logic [HALF_Q-1:0] en_lo,
  input logic [HALF_Q-1:0] st_lo,
  input logic [HALF_Q-1:0] en_hi,
  input logic [HALF_Q-1:0] st_hi,
  input logic              irq_lo,
  input logic              irq_hi
);
  localparam logic [REG_W-1:0] RSVD = ~field_mask();

  // R7
  sticky_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == A_ST_LO) |=> ((st_lo & $past(st_lo)) == $past(st_lo)));

  // R5
  gated_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_lo & ~$past(st_lo) & ~$past(en_lo)) == '0));

  // R6
  hi_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_hi & ~$past(st_hi) & $past(hi_near_empty)) == '0));

  // R2
  rsvd_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(reg_addr) < SRC_REGS) |-> ((reg_rdata & RSVD) == '0));

  // R8
  irq_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lo |-> ((st_lo & en_lo) != '0));

  // R8
  irq_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hi |-> ((st_hi & en_hi) != '0));
endmodule

bind qstat_irq_top qstat_irq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .hi_near_empty(hi_near_empty),
  .en_lo(en_lo), .st_lo(st_lo), .en_hi(en_hi), .st_hi(st_hi),
  .irq_lo(irq_lo), .irq_hi(irq_hi)
);

// File: tb/qstat_irq_top_tb_top.sv
`timescale 1ns/1ps
module qstat_irq_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] lo_empty = '0, lo_near_empty = '0, lo_near_full = '0, lo_full = '0;
  logic [31:0] hi_near_empty = '1, hi_full = '0;
  logic irq_lo, irq_hi;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  qstat_irq_top dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lo_empty(lo_empty), .lo_near_empty(lo_near_empty),
    .lo_near_full(lo_near_full), .lo_full(lo_full),
    .hi_near_empty(hi_near_empty), .hi_full(hi_full),
    .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  // {code[2:0], flags_before[3:0], flags_after[3:0]}; flags {full,nfull,nempty,empty}
  localparam logic [10:0] VEC [11] = '{
    {3'd0, 4'b0000, 4'b0001}, {3'd0, 4'b0001, 4'b0001},
    {3'd1, 4'b0000, 4'b0010}, {3'd2, 4'b0000, 4'b0100},
    {3'd3, 4'b0000, 4'b1000}, {3'd3, 4'b0000, 4'b0100},
    {3'd4, 4'b0001, 4'b0000}, {3'd5, 4'b0000, 4'b0010},
    {3'd6, 4'b0100, 4'b0000}, {3'd7, 4'b1000, 4'b0000},
    {3'd7, 4'b0000, 4'b1000}
  };

  function automatic logic sel_cond(logic [2:0] code, logic [3:0] fl);
    return fl[code[1:0]] ^ code[2];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #2 d = reg_rdata;
  endtask

  task automatic set_lo(int q, logic [3:0] fl);
    @(negedge clk);
    lo_empty[q] = fl[0]; lo_near_empty[q] = fl[1];
    lo_near_full[q] = fl[2]; lo_full[q] = fl[3];
  endtask

  // arm queue q with code, apply before/after flags, check status and irq
  task automatic run_lo(string req, int q, logic [2:0] code, logic [3:0] a, logic [3:0] b);
    logic [31:0] d;
    logic exp;
    exp = sel_cond(code, b) & ~sel_cond(code, a);
    wr(4'd4, 32'h0);
    wr(4'(q / 8), 32'(code) << ((q % 8) * 4));
    set_lo(q, a);
    repeat (2) @(negedge clk);
    wr(4'd6, 32'hFFFF_FFFF);
    wr(4'd4, 32'h1 << q);
    set_lo(q, b);
    rd(4'd6, d);
    check(req, d, 32'(exp) << q);
    check("R8", 32'(irq_lo), 32'(exp));
    set_lo(q, 4'b0000);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R10 reset state and unmapped space
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), d);
      check(a >= 10 ? "R10" : "R1", d, 32'h0);
    end
    check("R1", {30'h0, irq_hi, irq_lo}, 32'h0);

    // R3 / R4 vector table on queue 5
    for (int i = 0; i < 11; i++)
      run_lo("R3", 5, VEC[i][10:8], VEC[i][7:4], VEC[i][3:0]);

    // R2 reserved bits and field packing
    wr(4'd3, 32'hFFFF_FFFF);
    rd(4'd3, d);
    check("R2", d, 32'h7777_7777);
    run_lo("R2", 30, 3'd7, 4'b1000, 4'b0000);
    rd(4'd3, d);
    check("R2", d, 32'h0700_0000);
    run_lo("R4", 13, 3'd1, 4'b0000, 4'b0010);
    rd(4'd1, d);
    check("R2", d, 32'h0010_0000);

    // R5 edge while disabled does not set
    wr(4'd6, 32'hFFFF_FFFF);
    wr(4'd4, 32'h0);
    wr(4'd0, 32'h0);
    set_lo(5, 4'b0001);
    rd(4'd6, d);
    check("R5", d, 32'h0);
    // enabling while condition is already high does not set
    wr(4'd4, 32'h20);
    repeat (2) @(negedge clk);
    rd(4'd6, d);
    check("R5", d, 32'h0);
    set_lo(5, 4'b0000);
    wr(4'd4, 32'h0);

    // R6 upper queue 35 on falling nearly-empty
    wr(4'd5, 32'h8);
    @(negedge clk); hi_near_empty[3] = 1'b0;
    rd(4'd7, d);
    check("R6", d, 32'h8);
    check("R8", 32'(irq_hi), 32'h1);
    rd(4'd8, d);
    check("R9", d, 32'h8);

    // R7 write-0 keeps, write-1 clears
    wr(4'd7, 32'h0);
    rd(4'd7, d);
    check("R7", d, 32'h8);
    wr(4'd7, 32'h8);
    rd(4'd7, d);
    check("R7", d, 32'h0);
    // clear and new edge in the same cycle: set wins
    @(negedge clk); hi_near_empty[3] = 1'b1;
    repeat (2) @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'd7; reg_wdata = 32'h8; hi_near_empty[3] = 1'b0;
    @(negedge clk); reg_wr = 1'b0;
    rd(4'd7, d);
    check("R7", d, 32'h8);

    // R8 disabling masks the line, status kept
    wr(4'd5, 32'h0);
    #2 check("R8", 32'(irq_hi), 32'h0);
    rd(4'd7, d);
    check("R8", d, 32'h8);
    wr(4'd7, 32'h8);

    // R9 mirrors are read-only
    wr(4'd8, 32'h0);
    rd(4'd8, d);
    check("R9", d, 32'h8);
    @(negedge clk); hi_full[7] = 1'b1;
    wr(4'd9, 32'h0);
    rd(4'd9, d);
    check("R9", d, 32'h80);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule